// File: doc/BRIEF.md
# Bulk-Erase Programming Sequencer

This block sits on the programmer side of a two-wire serial programming port. It drives a programming clock and a data line from a fast system clock. It plays one of three fixed erase scripts into a target that is already in programming mode. All three scripts share a shape: a pre-load of an all-ones word, a two-command setup, a begin-erase command, a long timed wait, and a second setup pair.

A caller picks a script with `mode`: 0 erases program memory, 1 erases data memory, 2 runs the full erase used on code-protected targets. The caller pulses `start` to run it. While the sequence runs, `busy` stays high. A one-cycle `done` marks the end. Every time interval on the wire is counted in system-clock cycles, and a parameter sets each one:
- `HALF_CYC`: each clock half-period.
- `GAP_CYC`: the idle spacing placed after every frame.
- `WAIT_CYC`: the erase wait.

A bench can therefore shrink the millisecond wait. The target decodes the command codes, so those values are fixed.

Top module: `erase_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `pgc`, `pgd`, `pgd_oe`, `busy` and `done` are all low.
- R2: A `start` pulse while idle, with `mode` 0, 1 or 2, raises `busy` on the next clock edge. When the sequence ends, `done` is high for exactly one cycle, and in that same cycle `busy` is already low.
- R3: With `mode` 0 the frames sent are, in this order:
  - command 0x02 (load program word);
  - one data frame;
  - commands 0x01, 0x07, 0x08, 0x01, 0x07.
- R4: With `mode` 1 the sequence is the same as in R3, except that the first command is 0x03 (load data-memory word).
- R5: With `mode` 2 the frames sent are, in this order:
  - command 0x00 (load configuration);
  - one data frame;
  - `CFG_OFFSET` (default 7) copies of command 0x06 (advance address);
  - commands 0x01, 0x07, 0x08, 0x01, 0x07.
- R6: Every bit is sent LSb first on `pgd`.
  - `pgd` changes only in the cycle in which `pgc` rises, or while `pgc` is low.
  - Within a frame, every high phase and every low phase of `pgc` lasts exactly `HALF_CYC` cycles.
  - A command frame is 6 clocks long.
- R7: A data frame is 16 clocks. It carries value 0x7FFE LSb first: a 0 start bit, fourteen 1 bits, then a 0 stop bit.
- R8: `pgc` stays low between two frames.
  - Normally it stays low for exactly `HALF_CYC + GAP_CYC` cycles, counted from the last falling edge of one frame to the first rising edge of the next.
  - After the 0x08 command it stays low for `HALF_CYC + 2*GAP_CYC + WAIT_CYC` cycles.
- R9: `pgd_oe` is high whenever `pgc` or `pgd` is high, and it stays high for the whole sequence.
- R10: `start` has no effect in two cases:
  - when it comes with `mode` 3;
  - when it comes while a sequence is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run the selected script |
| mode | input | 2 | 0 program memory, 1 data memory, 2 full protected erase, 3 unused |
| pgc | output | 1 | Programming clock to the target |
| pgd | output | 1 | Programming data to the target |
| pgd_oe | output | 1 | Output enable for the data line driver |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence finishes |

## Verification
The bench decodes the wire into frames by watching `pgc` falls and the low spans between them.

- Frame order: a wrong first command, or a miscounted address-advance run, shows up as a frame mismatch.
- Data frame: a dropped start or stop bit changes the 0x7FFE value.
- Wait placement: a wait placed after the wrong frame moves the long low span.
- Clock timing: a data change while `pgc` is high, or a short half period, is counted as a timing violation.
- Start handling: a design that honours `start` with `mode` 3, or re-latches `mode` mid-run, would emit stray frames or a protected-erase script where a program erase was asked for.

// File: rtl/erase_seq.sv
module erase_seq #(
  parameter int HALF_CYC   = 100,
  parameter int GAP_CYC    = 200,
  parameter int WAIT_CYC   = 1600000,
  parameter int CFG_OFFSET = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] mode,
  output logic       pgc,
  output logic       pgd,
  output logic       pgd_oe,
  output logic       busy,
  output logic       done
);

  localparam int M1    = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int CMAX  = (M1 > WAIT_CYC) ? M1 : WAIT_CYC;
  localparam int CW    = $clog2(CMAX + 1);
  localparam int IDX_W = $clog2(CFG_OFFSET + 9);
  localparam logic [15:0] DATA_WORD = {1'b0, {14{1'b1}}, 1'b0};

  localparam logic [1:0] K_CMD = 2'd0, K_DATA = 2'd1, K_WAIT = 2'd2, K_END = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_HIGH, S_LOW, S_WAIT} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [15:0]      sh;
  logic [3:0]       nbit;
  logic [IDX_W-1:0] idx;
  logic [1:0]       mode_q;
  logic             pgc_q, pgd_q, oe_q, done_q;

  logic [1:0]       kind;
  logic [5:0]       code;
  logic [IDX_W-1:0] base, rel;

  assign base = (mode_q == 2'd2) ? IDX_W'(2 + CFG_OFFSET) : IDX_W'(2);
  assign rel  = idx - base;

  always_comb begin
    kind = K_CMD;
    code = 6'h00;
    if (idx == '0) begin
      case (mode_q)
        2'd0:    code = 6'h02;
        2'd1:    code = 6'h03;
        default: code = 6'h00;
      endcase
    end else if (idx == IDX_W'(1)) begin
      kind = K_DATA;
    end else if (idx < base) begin
      code = 6'h06;
    end else begin
      case (rel)
        IDX_W'(0), IDX_W'(4): code = 6'h01;
        IDX_W'(1), IDX_W'(5): code = 6'h07;
        IDX_W'(2):            code = 6'h08;
        IDX_W'(3):            kind = K_WAIT;
        default:              kind = K_END;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      nbit   <= '0;
      idx    <= '0;
      mode_q <= '0;
      pgc_q  <= 1'b0;
      pgd_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start && mode != 2'd3) begin
          mode_q <= mode;
          idx    <= '0;
          oe_q   <= 1'b1;
          cnt    <= CW'(GAP_CYC - 1);
          state  <= S_GAP;
        end
        S_GAP: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          case (kind)
            K_END: begin
              state  <= S_IDLE;
              oe_q   <= 1'b0;
              done_q <= 1'b1;
            end
            K_WAIT: begin
              state <= S_WAIT;
              cnt   <= CW'(WAIT_CYC - 1);
            end
            K_DATA: begin
              pgd_q <= DATA_WORD[0];
              sh    <= DATA_WORD >> 1;
              nbit  <= 4'd15;
              pgc_q <= 1'b1;
              cnt   <= CW'(HALF_CYC - 1);
              state <= S_HIGH;
            end
            default: begin
              pgd_q <= code[0];
              sh    <= {11'b0, code[5:1]};
              nbit  <= 4'd5;
              pgc_q <= 1'b1;
              cnt   <= CW'(HALF_CYC - 1);
              state <= S_HIGH;
            end
          endcase
        end
        S_HIGH: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          pgc_q <= 1'b0;
          cnt   <= CW'(HALF_CYC - 1);
          state <= S_LOW;
        end
        S_LOW: if (cnt != '0) cnt <= cnt - 1'b1;
        else if (nbit != '0) begin
          pgd_q <= sh[0];
          sh    <= sh >> 1;
          nbit  <= nbit - 1'b1;
          pgc_q <= 1'b1;
          cnt   <= CW'(HALF_CYC - 1);
          state <= S_HIGH;
        end else begin
          pgd_q <= 1'b0;
          idx   <= idx + 1'b1;
          cnt   <= CW'(GAP_CYC - 1);
          state <= S_GAP;
        end
        S_WAIT: if (cnt != '0) cnt <= cnt - 1'b1;
        else begin
          idx   <= idx + 1'b1;
          cnt   <= CW'(GAP_CYC - 1);
          state <= S_GAP;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pgc    = pgc_q;
  assign pgd    = pgd_q;
  assign pgd_oe = oe_q;
  assign busy   = (state != S_IDLE);
  assign done   = done_q;

  logic [CW-1:0] hi_run, lo_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= pgc ? hi_run + 1'b1 : '0;
      if (pgc)                         lo_run <= '0;
      else if (lo_run != CW'(HALF_CYC)) lo_run <= lo_run + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pgc && !pgd && !pgd_oe));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_pgd_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pgc && $past(pgc)) |-> $stable(pgd));
  assert_half_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pgc) |-> (hi_run == CW'(HALF_CYC)));
  assert_min_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgc) |-> (lo_run == CW'(HALF_CYC)));
  assert_oe_cover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pgc || pgd) |-> pgd_oe);
  assert_mode3_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && mode == 2'd3) |=> !busy);

endmodule

// File: tb/erase_seq_tb_top.sv
module erase_seq_tb_top;
  localparam int HALF = 4, GAP = 10, WT = 300, CFG = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic pgc, pgd, pgd_oe, busy, done;

  always #2.5 clk = ~clk;

  erase_seq #(.HALF_CYC(HALF), .GAP_CYC(GAP), .WAIT_CYC(WT), .CFG_OFFSET(CFG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .pgc(pgc), .pgd(pgd), .pgd_oe(pgd_oe), .busy(busy), .done(done));

  int n_chk = 0, n_fail = 0, cyc = 0;

  int f_len[0:31];
  logic [15:0] f_val[0:31];
  int f_low[0:31];
  int nf = 0, cur_bits = 0, lowrun = 0, stab_err = 0, oe_err = 0, hi_err = 0, hirun = 0, done_cnt = 0;
  logic [15:0] cur = '0;
  logic prev_pgc = 1'b0, prev_pgd = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic close_frame();
    if (nf < 32) begin
      f_len[nf] = cur_bits;
      f_val[nf] = cur;
      nf++;
    end
    cur = '0;
    cur_bits = 0;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pgc && !prev_pgc) begin
      if (cur_bits > 0 && lowrun > HALF) close_frame();
      if (cur_bits == 0 && nf < 32) f_low[nf] = lowrun;
      lowrun = 0;
    end
    if (!pgc && prev_pgc) begin
      if (hirun != HALF) hi_err++;
      if (cur_bits < 16) cur[cur_bits] = pgd;
      cur_bits++;
      hirun = 0;
    end
    if (pgc) hirun++;
    if (!pgc) lowrun++;
    if (pgc && prev_pgc && pgd != prev_pgd) stab_err++;
    if ((pgc || pgd) && !pgd_oe) oe_err++;
    if (done) begin
      done_cnt++;
      if (cur_bits > 0) close_frame();
    end
    prev_pgc = pgc;
    prev_pgd = pgd;
  end

  task automatic clear_log();
    nf = 0; cur_bits = 0; cur = '0; stab_err = 0; oe_err = 0; hi_err = 0; done_cnt = 0; hirun = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pgc == 0 && pgd == 0, "R1 reset pins", {pgc, pgd}, 0);
    chk(pgd_oe == 0 && busy == 0 && done == 0, "R1 reset status", {pgd_oe, busy, done}, 0);
  endtask

  task automatic run_seq(input int m, input bit poke, input string req);
    int e_len[0:31];
    int e_val[0:31];
    int ne = 0;
    int waited = 0;
    int first;
    first = (m == 0) ? 'h02 : (m == 1) ? 'h03 : 'h00;
    e_len[ne] = 6; e_val[ne] = first; ne++;
    e_len[ne] = 16; e_val[ne] = 'h7FFE; ne++;
    if (m == 2) for (int i = 0; i < CFG; i++) begin e_len[ne] = 6; e_val[ne] = 'h06; ne++; end
    e_len[ne] = 6; e_val[ne] = 'h01; ne++;
    e_len[ne] = 6; e_val[ne] = 'h07; ne++;
    e_len[ne] = 6; e_val[ne] = 'h08; ne++;
    e_len[ne] = 6; e_val[ne] = 'h01; ne++;
    e_len[ne] = 6; e_val[ne] = 'h07; ne++;
    clear_log();
    @(negedge clk); start = 1'b1; mode = m[1:0];
    @(negedge clk); start = 1'b0; mode = 2'd3;
    chk(busy == 1, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1'b1; mode = 2'd2;
      @(negedge clk); start = 1'b0; mode = 2'd3;
    end
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    chk(done == 1, "R2 done seen", done, 1);
    chk(busy == 0, "R2 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R2 done one cycle", done, 0);
    chk(done_cnt == 1, "R2 single done", done_cnt, 1);
    chk(nf == ne, {req, " frame count"}, nf, ne);
    for (int i = 0; i < ne && i < nf; i++) begin
      chk(f_len[i] == e_len[i], {req, " R6/R7 frame length"}, f_len[i], e_len[i]);
      chk(f_val[i] == e_val[i], {req, " frame value"}, f_val[i], e_val[i]);
      if (i > 0) begin
        int el;
        el = (e_val[i-1] == 'h08 && e_len[i-1] == 6) ? HALF + 2*GAP + WT : HALF + GAP;
        chk(f_low[i] == el, "R8 inter-frame low span", f_low[i], el);
      end
    end
    chk(stab_err == 0, "R6 pgd stable while pgc high", stab_err, 0);
    chk(hi_err == 0, "R6 high phase length", hi_err, 0);
    chk(oe_err == 0, "R9 output enable", oe_err, 0);
    chk(pgd_oe == 0 && pgc == 0, "R1 quiet after done", {pgd_oe, pgc}, 0);
  endtask

  task automatic t_mode3();
    clear_log();
    @(negedge clk); start = 1'b1; mode = 2'd3;
    @(negedge clk); start = 1'b0;
    chk(busy == 0, "R10 mode 3 no busy", busy, 0);
    repeat (60) @(negedge clk);
    chk(nf == 0 && cur_bits == 0, "R10 mode 3 no frames", nf + cur_bits, 0);
    chk(pgd_oe == 0, "R10 mode 3 oe low", pgd_oe, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_seq(0, 1'b0, "R3 program erase");
    run_seq(1, 1'b0, "R4 data erase");
    run_seq(2, 1'b0, "R5 full erase");
    t_mode3();
    run_seq(0, 1'b1, "R10 start while busy ignored");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule